// File: doc/BRIEF.md
# Per-Pin Interrupt Detector with Sticky Status

This block watches the input levels of a 32-pin port and raises an interrupt when a pin meets the condition chosen for it. Every pin is brought through a two-stage synchronizer. Each pin has its own control word holding a 4-bit detection code. That code selects one of five modes: a rising edge, a falling edge, either edge, a high level or a low level. Any other code turns detection off for that pin.

A detection sets that pin's flag in a shared status word. The flag stays set until software writes a 1 to its bit. One interrupt line, the registered OR of all flags, goes to the interrupt controller.

Software reaches the control words and the status word through a simple 32-bit register bus. The bus has a request strobe, a write enable, a byte address and write data. Read data is returned one clock after a read request and is held until the next read.

Top module: `irqd_port`

## Requirements
- R1: After reset every detection code is 0 (disabled), every status flag is 0, `irq_o` is 0 and `bus_rdata_o` is 0.
- R2: The control word of pin p is at byte address 4*p (0x00 to 0x7C). Its detection code is written from and read back on bits 19:16. All other bits of a control word read as 0, and write data in those bits has no effect. Writing 0 to a control word disables that pin. A read returns its data on `bus_rdata_o` at the first clock edge after the request, and the value is held until the next read.
- R3: Code 0x9 sets a pin's flag when its synchronized level goes from 0 to 1.
- R4: Code 0xA sets a pin's flag when its synchronized level goes from 1 to 0.
- R5: Code 0xB sets a pin's flag on both kinds of transition.
- R6: Code 0xC sets the flag on every clock while the synchronized level is 1. Code 0x8 does the same while the level is 0. A clear has no lasting effect while the level condition holds.
- R7: Code 0x0 and every code other than 0x8, 0x9, 0xA, 0xB and 0xC never set a flag.
- R8: The status word is at byte address 0xA0, with bit p the flag of pin p. Writing it clears each flag whose data bit is 1 and leaves flags under 0 bits unchanged, so writing all ones clears every flag. A read of any address that is neither a control word nor the status word returns 0.
- R9: If a detection and a clear of the same bit fall on the same clock, the detection wins and the flag stays set.
- R10: The previous-level register of each pin is updated while the pin is disabled. Enabling an edge mode on a pin that has been steady therefore does not set its flag.
- R11: `irq_o` equals the OR of all status flags as they stood one clock earlier.
- R12: A set flag stays set until it is cleared, whatever the pin does afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 32 | Asynchronous pin levels |
| bus_req_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte address (bits 1:0 ignored) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Suppose a pin changes just after clock edge E0. The synchronizer presents the new level after E2, the flag is set at E3, and `irq_o` follows at E4. Read data is due at the edge that ends the request cycle. A clear or control write takes effect at that same edge. The bench keeps a cycle-level reference model that advances on every edge and compares every output one nanosecond after the edge. Directed checks then wait at least four edges after a pin change before reading status. The one exception is the same-cycle priority case, where the clear is placed at exactly E3.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

  typedef enum logic [3:0] {
    IRQC_OFF    = 4'h0,
    IRQC_LVL_LO = 4'h8,
    IRQC_RISE   = 4'h9,
    IRQC_FALL   = 4'hA,
    IRQC_BOTH   = 4'hB,
    IRQC_LVL_HI = 4'hC
  } irqc_e;

  typedef struct packed {
    logic lvl_lo;
    logic lvl_hi;
    logic rise;
    logic fall;
  } det_sel_t;

  function automatic det_sel_t decode_irqc(logic [3:0] code);
    det_sel_t s;
    s = '0;
    case (code)
      IRQC_LVL_LO: s.lvl_lo = 1'b1;
      IRQC_LVL_HI: s.lvl_hi = 1'b1;
      IRQC_RISE:   s.rise   = 1'b1;
      IRQC_FALL:   s.fall   = 1'b1;
      IRQC_BOTH: begin
        s.rise = 1'b1;
        s.fall = 1'b1;
      end
      default: s = '0;  // unlisted codes act as disabled
    endcase
    return s;
  endfunction

endpackage

// File: rtl/irqd_sync.sv
module irqd_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[s] <= '0;
          else         chain_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[s] <= '0;
          else         chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/irqd_pin_detect.sv
module irqd_pin_detect
  import irqd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lvl_i,
  input  logic [3:0] cfg_i,
  output logic       evt_o
);

  logic     prev_q;
  det_sel_t sel;

  // tracks level regardless of mode so enabling never sees a stale edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign sel   = decode_irqc(cfg_i);
  assign evt_o = (sel.lvl_hi &  lvl_i)
               | (sel.lvl_lo & ~lvl_i)
               | (sel.rise   &  lvl_i & ~prev_q)
               | (sel.fall   & ~lvl_i &  prev_q);

endmodule

// File: rtl/irqd_regfile.sv
module irqd_regfile #(
  parameter int          NUM_PINS  = 32,
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 32,
  parameter int          FIELD_LSB = 16,
  parameter logic [7:0]  STAT_ADDR = 8'hA0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     bus_req_i,
  input  logic                     bus_we_i,
  input  logic [ADDR_W-1:0]        bus_addr_i,
  input  logic [DATA_W-1:0]        bus_wdata_i,
  output logic [DATA_W-1:0]        bus_rdata_o,
  input  logic [NUM_PINS-1:0]      stat_i,
  output logic [NUM_PINS-1:0]      clr_o,
  output logic [NUM_PINS-1:0][3:0] cfg_o
);

  localparam int IDX_W = ADDR_W - 2;
  localparam int PIN_W = $clog2(NUM_PINS);
  localparam logic [IDX_W-1:0] STAT_IDX = IDX_W'(STAT_ADDR >> 2);

  logic [IDX_W-1:0]  idx;
  logic              ctrl_sel, stat_sel, wr, rd;
  logic [DATA_W-1:0] rd_word;
  logic              unused_addr_lsb;

  assign idx             = bus_addr_i[ADDR_W-1:2];
  assign unused_addr_lsb = ^bus_addr_i[1:0];
  assign ctrl_sel        = idx < IDX_W'(NUM_PINS);
  assign stat_sel        = idx == STAT_IDX;
  assign wr              = bus_req_i &  bus_we_i;
  assign rd              = bus_req_i & ~bus_we_i;

  assign clr_o = (wr && stat_sel) ? bus_wdata_i[NUM_PINS-1:0] : '0;

  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_cfg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          cfg_o[p] <= 4'h0;
        else if (wr && ctrl_sel && idx == IDX_W'(p))
          cfg_o[p] <= bus_wdata_i[FIELD_LSB +: 4];
      end
    end
  endgenerate

  always_comb begin
    rd_word = '0;
    if (ctrl_sel)
      rd_word[FIELD_LSB +: 4] = cfg_o[idx[PIN_W-1:0]];
    else if (stat_sel)
      rd_word[NUM_PINS-1:0] = stat_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  bus_rdata_o <= '0;
    else if (rd)  bus_rdata_o <= rd_word;
  end

endmodule

// File: rtl/irqd_port.sv
module irqd_port #(
  parameter int         NUM_PINS    = 32,
  parameter int         SYNC_STAGES = 2,
  parameter int         ADDR_W      = 8,
  parameter int         DATA_W      = 32,
  parameter int         FIELD_LSB   = 16,
  parameter logic [7:0] STAT_ADDR   = 8'hA0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                bus_req_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  output logic                irq_o
);

  logic [NUM_PINS-1:0]      lvl_s;
  logic [NUM_PINS-1:0]      evt;
  logic [NUM_PINS-1:0]      clr;
  logic [NUM_PINS-1:0]      stat_q;
  logic [NUM_PINS-1:0][3:0] cfg;

  irqd_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (lvl_s)
  );

  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      irqd_pin_detect u_det (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .lvl_i (lvl_s[p]),
        .cfg_i (cfg[p]),
        .evt_o (evt[p])
      );
    end
  endgenerate

  irqd_regfile #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .FIELD_LSB(FIELD_LSB),
    .STAT_ADDR(STAT_ADDR)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_req_i  (bus_req_i),
    .bus_we_i   (bus_we_i),
    .bus_addr_i (bus_addr_i),
    .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o),
    .stat_i     (stat_q),
    .clr_o      (clr),
    .cfg_o      (cfg)
  );

  // new detection takes priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr) | evt;
      irq_o  <= |stat_q;
    end
  end

endmodule

// File: rtl/irqd_port_chk.sv
module irqd_port_chk #(
  parameter int         NUM_PINS  = 32,
  parameter int         ADDR_W    = 8,
  parameter int         DATA_W    = 32,
  parameter logic [7:0] STAT_ADDR = 8'hA0
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     bus_req_i,
  input logic                     bus_we_i,
  input logic [ADDR_W-1:0]        bus_addr_i,
  input logic [DATA_W-1:0]        bus_wdata_i,
  input logic [DATA_W-1:0]        bus_rdata_o,
  input logic                     irq_o,
  input logic [NUM_PINS-1:0]      stat_q,
  input logic [NUM_PINS-1:0][3:0] cfg
);

  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] STAT_IDX = IDX_W'(STAT_ADDR >> 2);

  logic [NUM_PINS-1:0] clr_vec;
  logic [NUM_PINS-1:0] live_mask;
  logic [IDX_W-1:0]    idx;
  logic                unmapped_rd;

  assign idx         = bus_addr_i[ADDR_W-1:2];
  assign clr_vec     = (bus_req_i && bus_we_i && idx == STAT_IDX) ? bus_wdata_i[NUM_PINS-1:0] : '0;
  assign unmapped_rd = bus_req_i && !bus_we_i && idx >= IDX_W'(NUM_PINS) && idx != STAT_IDX;

  always_comb begin
    for (int p = 0; p < NUM_PINS; p++)
      live_mask[p] = cfg[p] inside {4'h8, 4'h9, 4'hA, 4'hB, 4'hC};
  end

  // R12: flags only drop where a clear was written
  a_r12_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(stat_q) & ~$past(clr_vec)) & ~stat_q) == '0));

  // R7: flags only rise on pins with a valid mode
  a_r7_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(live_mask)) == '0));

  // R11
  a_r11_irq_registered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == |$past(stat_q)));

  // R2: read data holds without a read
  a_r2_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_req_i && !bus_we_i) |=> $stable(bus_rdata_o));

  // R8
  a_r8_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped_rd |=> (bus_rdata_o == '0));

endmodule

bind irqd_port irqd_port_chk #(
  .NUM_PINS (NUM_PINS),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_req_i  (bus_req_i),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .bus_rdata_o(bus_rdata_o),
  .irq_o      (irq_o),
  .stat_q     (stat_q),
  .cfg        (cfg)
);

// File: tb/sim_irqd_port.sv
`timescale 1ns/1ps
module sim_irqd_port;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pins = '0;
  logic        b_req = 1'b0, b_we = 1'b0;
  logic [7:0]  b_addr = '0;
  logic [31:0] b_wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model state
  logic [31:0] m_s1 = '0, m_s2 = '0, m_prev = '0, m_stat = '0, m_rdata = '0;
  logic        m_irq = 1'b0;
  logic [3:0]  m_mode [32];

  always #4 clk_i = ~clk_i;

  irqd_port u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pins),
    .bus_req_i(b_req), .bus_we_i(b_we), .bus_addr_i(b_addr),
    .bus_wdata_i(b_wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic fn_event(logic [3:0] mode, logic s, logic prev);
    case (mode)
      4'h8: return !s;
      4'hC: return s;
      4'h9: return s && !prev;
      4'hA: return !s && prev;
      4'hB: return s != prev;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] fn_read(logic [7:0] a);
    if (a < 8'h80)       return {12'h0, m_mode[a[6:2]], 16'h0};
    if (a[7:2] == 6'h28) return m_stat;
    return 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    logic [31:0] ev, clr, nstat, nrd, pn;
    logic rd_now, ctrl_wr;
    for (int p = 0; p < 32; p++) ev[p] = fn_event(m_mode[p], m_s2[p], m_prev[p]);
    clr     = (b_req && b_we && b_addr[7:2] == 6'h28) ? b_wdata : 32'h0;
    rd_now  = b_req && !b_we;
    ctrl_wr = b_req && b_we && b_addr < 8'h80;
    nrd     = rd_now ? fn_read(b_addr) : m_rdata;
    nstat   = (m_stat & ~clr) | ev;
    pn      = pins;
    @(posedge clk_i);
    #1;
    m_irq   = |m_stat;
    m_stat  = nstat;
    m_prev  = m_s2;
    m_s2    = m_s1;
    m_s1    = pn;
    if (ctrl_wr) m_mode[b_addr[6:2]] = b_wdata[19:16];
    m_rdata = nrd;
    chk("R11 irq", {31'h0, irq}, {31'h0, m_irq});
    if (rd_now) begin
      if (b_addr[7:2] == 6'h28) chk("R8 status read", rdata, m_rdata);
      else                      chk("R2 read", rdata, m_rdata);
    end
    b_req = 1'b0;
    b_we  = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    b_req = 1'b1; b_we = 1'b1; b_addr = a; b_wdata = d;
    tick();
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    b_req = 1'b1; b_we = 1'b0; b_addr = a;
    tick();
    v = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h1D5EED));
    for (int p = 0; p < 32; p++) m_mode[p] = 4'h0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    chk("R1 irq after reset", {31'h0, irq}, 32'h0);
    chk("R1 rdata after reset", rdata, 32'h0);

    // R1
    rd(8'hA0, v); chk("R1 status", v, 32'h0);
    rd(8'h14, v); chk("R1 ctrl", v, 32'h0);

    // R2
    wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, v); chk("R2 field only", v, 32'h000F_0000);
    wr(8'h7C, 32'h0009_0000); rd(8'h7C, v); chk("R2 last pin", v, 32'h0009_0000);
    rd(8'h90, v); chk("R8 unmapped", v, 32'h0);

    // R7: pin 3 unlisted code, pin 4 code 0
    wr(8'h10, 32'h0);
    pins[3] = 1; pins[4] = 1; idle(4);
    pins[3] = 0; pins[4] = 0; idle(4);
    rd(8'hA0, v); chk("R7 no flags", v & 32'h18, 32'h0);

    // R3, R12, R11, R8
    wr(8'h00, 32'h0009_0000);
    pins[0] = 1; idle(4);
    rd(8'hA0, v); chk("R3 rise flag", v & 32'h1, 32'h1);
    pins[0] = 0; idle(4);
    rd(8'hA0, v); chk("R12 sticky", v & 32'h1, 32'h1);
    chk("R11 irq high", {31'h0, irq}, 32'h1);
    wr(8'hA0, 32'h1); idle(2);
    rd(8'hA0, v); chk("R8 w1c", v & 32'h1, 32'h0);
    chk("R11 irq low", {31'h0, irq}, 32'h0);

    // R4
    wr(8'h04, 32'h000A_0000);
    pins[1] = 1; idle(4);
    rd(8'hA0, v); chk("R4 no flag on rise", v & 32'h2, 32'h0);
    pins[1] = 0; idle(4);
    rd(8'hA0, v); chk("R4 fall flag", v & 32'h2, 32'h2);
    wr(8'hA0, 32'h2);

    // R5
    wr(8'h08, 32'h000B_0000);
    pins[2] = 1; idle(4);
    rd(8'hA0, v); chk("R5 rise", v & 32'h4, 32'h4);
    wr(8'hA0, 32'h4);
    pins[2] = 0; idle(4);
    rd(8'hA0, v); chk("R5 fall", v & 32'h4, 32'h4);
    wr(8'hA0, 32'h4);

    // R6 level high on pin 5, level low on pin 6
    wr(8'h14, 32'h000C_0000);
    pins[5] = 1; idle(4);
    wr(8'hA0, 32'h20); idle(1);
    rd(8'hA0, v); chk("R6 level high persists", v & 32'h20, 32'h20);
    pins[5] = 0; idle(4);
    wr(8'hA0, 32'h20); idle(1);
    rd(8'hA0, v); chk("R6 level high released", v & 32'h20, 32'h0);
    wr(8'h18, 32'h0008_0000); idle(2);
    rd(8'hA0, v); chk("R6 level low", v & 32'h40, 32'h40);
    pins[6] = 1; idle(4);
    wr(8'hA0, 32'h40); idle(1);
    rd(8'hA0, v); chk("R6 level low released", v & 32'h40, 32'h0);
    wr(8'h14, 32'h0); wr(8'h18, 32'h0);

    // R10
    pins[7] = 1; idle(5);
    wr(8'h1C, 32'h0009_0000); idle(4);
    rd(8'hA0, v); chk("R10 no false edge", v & 32'h80, 32'h0);
    wr(8'h1C, 32'h000B_0000); idle(4);
    rd(8'hA0, v); chk("R10 no false either", v & 32'h80, 32'h0);

    // R9: clear lands on the edge where the event registers
    wr(8'h24, 32'h000B_0000);
    pins[9] = 1; idle(4);
    pins[9] = 0; tick(); tick();
    wr(8'hA0, 32'h200);
    rd(8'hA0, v); chk("R9 detect wins", v & 32'h200, 32'h200);
    wr(8'hA0, 32'h200); idle(1);
    rd(8'hA0, v); chk("R9 later clear", v & 32'h200, 32'h0);

    // R8 zero bits and full clear
    wr(8'h28, 32'h0009_0000); wr(8'h2C, 32'h0009_0000);
    pins[10] = 1; pins[11] = 1; idle(4);
    wr(8'hA0, 32'h0);
    rd(8'hA0, v); chk("R8 zero bits keep", v & 32'hC00, 32'hC00);
    wr(8'hA0, 32'hFFFF_FFFF);
    rd(8'hA0, v); chk("R8 clear all", v, 32'h0);

    // random mix, checked against the model every cycle
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      if ($urandom % 4 == 0) pins = pins ^ (32'h1 << ($urandom % 32));
      r = $urandom % 10;
      if (r == 0) begin
        logic [3:0] code;
        case ($urandom % 7)
          0: code = 4'h0; 1: code = 4'h8; 2: code = 4'h9; 3: code = 4'hA;
          4: code = 4'hB; 5: code = 4'hC; default: code = 4'($urandom);
        endcase
        wr(8'(($urandom % 32) * 4), ($urandom & 32'hFFF0_FFFF) | {12'h0, code, 16'h0});
      end else if (r == 1) begin
        wr(8'hA0, $urandom);
      end else if (r <= 3) begin
        int unsigned a;
        a = $urandom % 48;
        rd(8'(a * 4), v);
      end else begin
        tick();
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule